// File: doc/BRIEF.md
# Windowed Watchdog Timer with Write-Once Configuration

This block is a watchdog timer with a small register interface. A 12-bit down-counter decrements on a tick made by dividing a slow-clock enable strobe by a fixed prescaler. Software must restart the counter before it underflows, and it must not restart too early. The earliest legal restart is set by a window value. A restart is accepted only when the control write carries the correct key.

When a fault occurs, the block sets a status flag. A fault is either an underflow or a restart that arrives too early. Depending on the configuration, the fault then drives a level interrupt, a fixed-length reset pulse, or both. The configuration register can be written once after reset; after that it is locked, so a running watchdog cannot be turned off. Status flags clear when they are read. Counting can be frozen while a debug-halt or idle input is asserted, if the matching configuration bit allows it.

The block is clocked by the system clock. The slow clock arrives as a one-cycle enable strobe in that domain.

Top module: `wwdt_top`

## Requirements
- R1: Out of reset the counter holds 0xFFF and the configuration reads 0x01FFFFFF (reload 0xFFF, window 0xFFF, reset-enable set). The reset and interrupt outputs are low. The counter value is readable at word offset 3.
- R2: A control write at offset 0 restarts the watchdog when it carries key 0xA5 in bits 31:24 and bit 0 set, and the counter is at or below the window (or the window is at or above the reload). A restart loads the counter with the reload value and clears the prescaler phase.
- R3: A control write with any other key changes no state: no flag is set and the counter is not reloaded.
- R4: Configuration sits at offset 1 with reload in bits 11:0, window in 23:12, reset-enable 24, interrupt-enable 25, debug-halt 26 and idle-halt 27. The first write after reset is accepted and loads the counter with the new reload value. Every later write is ignored.
- R5: A tick that finds the counter at 0 sets underflow flag (status bit 0) and reloads the counter. The first underflow therefore occurs (reload+1)·PRESCALE slow strobes after a load.
- R6: A keyed restart while the counter is above the window, with the window below the reload, sets error flag (status bit 1) and does not reload the counter.
- R7: Reading status at offset 2 clears both flags after the read. A fault in the same cycle as the read still sets its flag.
- R8: The interrupt output is high exactly while interrupt-enable is set and either status flag is set.
- R9: When reset-enable is set, every fault starts a reset pulse that stays high for RST_LEN (16) system clock cycles.
- R10: While debug-halt is set and dbg_i is high, or idle-halt is set and idle_i is high, the counter and prescaler hold. If the matching configuration bit is clear, that input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slow_en_i | input | 1 | One-cycle strobe per slow-clock period |
| dbg_i | input | 1 | Debugger halt request |
| idle_i | input | 1 | Processor idle indication |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 2 | Word offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle |
| irq_o | output | 1 | Fault interrupt level |
| wdt_rst_o | output | 1 | System reset request pulse |

## Verification
The assertions assume that the register access signals are stable around each clock edge. They also assume that a status read is a single request with no write. The stimulus respects both: it changes inputs only at falling edges and keeps each access to one cycle. The halt assertion assumes that no configuration load and no accepted restart happen during the halt, and the bench issues neither while dbg_i or idle_i is high. The bench uses a prescaler of 2 and small reload values, so it can sweep every reload from 0 to 7. It also sweeps every pairing of window and restart point for one reload.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
  localparam int unsigned CNT_W = 12;
  localparam logic [7:0]  RESTART_KEY = 8'hA5;

  localparam logic [1:0] OFS_CTRL  = 2'd0;
  localparam logic [1:0] OFS_MODE  = 2'd1;
  localparam logic [1:0] OFS_STAT  = 2'd2;
  localparam logic [1:0] OFS_VALUE = 2'd3;

  typedef struct packed {
    logic             idle_halt;
    logic             dbg_halt;
    logic             irq_en;
    logic             rst_en;
    logic [CNT_W-1:0] window;
    logic [CNT_W-1:0] reload;
  } mode_t;

  localparam int unsigned MODE_W = $bits(mode_t);

  localparam mode_t MODE_RST = '{
    idle_halt: 1'b0, dbg_halt: 1'b0, irq_en: 1'b0, rst_en: 1'b1,
    window: {CNT_W{1'b1}}, reload: {CNT_W{1'b1}}
  };

  typedef struct packed {
    logic err;
    logic uf;
  } stat_t;
endpackage

// File: rtl/wwdt_prescaler.sv
module wwdt_prescaler #(
  parameter int unsigned PRESCALE = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ph_q <= '0;
    else if (clear_i)       ph_q <= '0;
    else if (run_i) begin
      if (ph_q == LAST)     ph_q <= '0;
      else                  ph_q <= ph_q + 1'b1;
    end
  end

  assign tick_o = run_i && !clear_i && (ph_q == LAST);
endmodule

// File: rtl/wwdt_counter.sv
module wwdt_counter
  import wwdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic [CNT_W-1:0] window_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             restart_ok_o,
  output logic             early_o,
  output logic             underflow_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             win_active;

  // window check is off once window reaches reload
  assign win_active   = window_i < reload_i;
  assign early_o      = restart_i && win_active && (cnt_q > window_i);
  assign restart_ok_o = restart_i && !early_o && !load_i;
  assign underflow_o  = tick_i && (cnt_q == '0) && !load_i && !restart_ok_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= {CNT_W{1'b1}};
    else if (load_i)       cnt_q <= load_val_i;
    else if (restart_ok_o) cnt_q <= reload_i;
    else if (tick_i) begin
      if (cnt_q == '0)     cnt_q <= reload_i;
      else                 cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wwdt_regs.sv
module wwdt_regs
  import wwdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [31:0]      wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             uf_i,
  input  logic             err_i,
  output mode_t            mode_o,
  output stat_t            stat_o,
  output logic             locked_o,
  output logic             mode_load_o,
  output logic             restart_o,
  output logic [31:0]      rdata_o
);
  mode_t mode_q;
  stat_t stat_q;
  logic  locked_q;
  logic  wr, rd_stat;

  assign wr          = req_i && we_i;
  assign rd_stat     = req_i && !we_i && (addr_i == OFS_STAT);
  assign mode_load_o = wr && (addr_i == OFS_MODE) && !locked_q;
  assign restart_o   = wr && (addr_i == OFS_CTRL) &&
                       (wdata_i[31:24] == RESTART_KEY) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_RST;
      locked_q <= 1'b0;
    end else if (mode_load_o) begin
      mode_q   <= mode_t'(wdata_i[MODE_W-1:0]);
      locked_q <= 1'b1;
    end
  end

  // new events win over the clear-on-read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else begin
      stat_q.uf  <= (stat_q.uf  && !rd_stat) || uf_i;
      stat_q.err <= (stat_q.err && !rd_stat) || err_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      unique case (addr_i)
        OFS_MODE:  rdata_o = 32'(mode_q);
        OFS_STAT:  rdata_o = 32'(stat_q);
        OFS_VALUE: rdata_o = 32'(cnt_i);
        default:   rdata_o = '0;
      endcase
    end
  end

  assign mode_o   = mode_q;
  assign stat_o   = stat_q;
  assign locked_o = locked_q;
endmodule

// File: rtl/wwdt_rst_pulse.sv
module wwdt_rst_pulse #(
  parameter int unsigned RST_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int unsigned LW = $clog2(RST_LEN + 1);

  logic [LW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            left_q <= '0;
    else if (trig_i)        left_q <= LW'(RST_LEN);
    else if (left_q != '0)  left_q <= left_q - 1'b1;
  end

  assign pulse_o = left_q != '0;
endmodule

// File: rtl/wwdt_top.sv
module wwdt_top
  import wwdt_pkg::*;
#(
  parameter int unsigned PRESCALE = 128,
  parameter int unsigned RST_LEN  = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        slow_en_i,
  input  logic        dbg_i,
  input  logic        idle_i,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o,
  output logic        wdt_rst_o
);
  mode_t            mode;
  stat_t            stat;
  logic             locked, mode_load, restart_req, restart_ok;
  logic             early, underflow, tick, halted, fault;
  logic [CNT_W-1:0] cnt;

  assign halted = (mode.dbg_halt && dbg_i) || (mode.idle_halt && idle_i);
  assign fault  = early || underflow;

  wwdt_regs u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .cnt_i       (cnt),
    .uf_i        (underflow),
    .err_i       (early),
    .mode_o      (mode),
    .stat_o      (stat),
    .locked_o    (locked),
    .mode_load_o (mode_load),
    .restart_o   (restart_req),
    .rdata_o
  );

  wwdt_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk_i, .rst_ni,
    .clear_i (mode_load || restart_ok),
    .run_i   (slow_en_i && !halted),
    .tick_o  (tick)
  );

  wwdt_counter u_cnt (
    .clk_i, .rst_ni,
    .tick_i       (tick),
    .load_i       (mode_load),
    .load_val_i   (wdata_i[CNT_W-1:0]),
    .restart_i    (restart_req),
    .reload_i     (mode.reload),
    .window_i     (mode.window),
    .cnt_o        (cnt),
    .restart_ok_o (restart_ok),
    .early_o      (early),
    .underflow_o  (underflow)
  );

  wwdt_rst_pulse #(.RST_LEN(RST_LEN)) u_rst (
    .clk_i, .rst_ni,
    .trig_i  (fault && mode.rst_en),
    .pulse_o (wdt_rst_o)
  );

  assign irq_o = mode.irq_en && (stat.uf || stat.err);
endmodule

// File: rtl/wwdt_chk.sv
module wwdt_chk
  import wwdt_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             halted,
  input logic             mode_load,
  input logic             restart_ok,
  input logic             locked,
  input logic             req_i,
  input logic             we_i,
  input logic [1:0]       addr_i,
  input logic [31:0]      wdata_i,
  input logic [CNT_W-1:0] cnt,
  input mode_t            mode,
  input stat_t            stat,
  input logic             irq_o,
  input logic             wdt_rst_o
);
  // R10
  halt_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted && !mode_load && !restart_ok |=> $stable(cnt));

  // R4
  mode_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |=> $stable(mode) && locked);

  // R3
  bad_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && addr_i == OFS_CTRL && wdata_i[31:24] != RESTART_KEY
    |=> !$rose(stat.err));

  // R9
  rst_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> $past(mode.rst_en));

  // R8
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (stat.uf || stat.err) && mode.irq_en);
endmodule

bind wwdt_top wwdt_chk u_chk (
  .clk_i, .rst_ni, .halted,
  .mode_load, .restart_ok, .locked,
  .req_i, .we_i, .addr_i, .wdata_i,
  .cnt, .mode, .stat, .irq_o, .wdt_rst_o
);

// File: tb/wwdt_top_tb_top.sv
module wwdt_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int P = 2;
  localparam int RLEN = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_en = 1'b1;
  logic        dbg = 1'b0, idle = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, wrst;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wwdt_top #(.PRESCALE(P), .RST_LEN(RLEN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .slow_en_i(slow_en), .dbg_i(dbg),
    .idle_i(idle), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .wdt_rst_o(wrst)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    req = 0; we = 0; dbg = 0; idle = 0;
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  // called at a falling edge; write lands on the next rising edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] d);
    req = 1; we = 0; addr = a;
    #1 d = rdata;
    req = 0;
  endtask

  task automatic rd_stat(output logic [31:0] d);
    req = 1; we = 0; addr = 2'd2;
    #1 d = rdata;
    @(posedge clk);
    @(negedge clk);
    req = 0;
  endtask

  function automatic logic [31:0] mk_mode(int rl, int wn, bit re, bit ie, bit dh, bit ih);
    return {4'b0, ih, dh, ie, re, 12'(wn), 12'(rl)};
  endfunction

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none
  end

  initial begin
    logic [31:0] d, v1, v2;
    int n;
    bit saw_rst;

    do_reset();
    @(negedge clk);
    // R1 reset state
    peek(2'd3, d); chk(d == 32'hFFF, "R1 value", d, 32'hFFF);
    peek(2'd1, d); chk(d == 32'h01FFFFFF, "R1 mode", d, 32'h01FFFFFF);
    chk(!irq && !wrst, "R1 outputs", {irq, wrst}, 0);

    // R5 R8 R7: timeout sweep over reloads 0..7
    for (int r = 0; r < 8; r++) begin
      do_reset();
      @(negedge clk);
      wr(2'd1, mk_mode(r, r, 0, 1, 0, 0));
      n = 0; saw_rst = 0;
      while (!irq && n < 1000) begin
        @(posedge clk); #1;
        n++;
        if (wrst) saw_rst = 1;
      end
      chk(n == (r + 1) * P, "R5 timeout", n, (r + 1) * P);
      chk(!saw_rst, "R9 no pulse when disabled", saw_rst, 0);
      @(negedge clk);
      rd_stat(d); chk(d == 32'h1, "R5 underflow flag", d, 1);
      chk(!irq, "R7 R8 irq cleared", irq, 0);
      rd_stat(d); chk(d == 32'h0, "R7 flags cleared", d, 0);
    end

    // R4 lock, R3 bad key, R6 early, R9 pulse
    do_reset();
    @(negedge clk);
    wr(2'd1, mk_mode(20, 10, 1, 1, 0, 0));
    wr(2'd1, mk_mode(3, 3, 0, 0, 0, 0));
    peek(2'd1, d);
    chk(d == mk_mode(20, 10, 1, 1, 0, 0), "R4 second write ignored", d, mk_mode(20, 10, 1, 1, 0, 0));
    wr(2'd0, 32'h5A000001);
    chk(!irq && !wrst, "R3 bad key no fault", {irq, wrst}, 0);
    peek(2'd3, v1);
    chk(v1 < 20, "R3 bad key no reload", v1, 19);
    wr(2'd0, 32'hA5000001);
    peek(2'd3, v2);
    chk(v2 <= v1, "R6 early restart no reload", v2, v1);
    chk(irq, "R6 R8 irq on error", irq, 1);
    n = 0;
    while (wrst && n < 100) begin n++; @(negedge clk); end
    chk(n == RLEN, "R9 pulse length", n, RLEN);
    rd_stat(d); chk(d == 32'h2, "R6 error flag", d, 2);

    // R10 halt with debug bit set, idle bit clear
    do_reset();
    @(negedge clk);
    wr(2'd1, mk_mode(200, 200, 0, 0, 1, 0));
    dbg = 1;
    peek(2'd3, v1);
    repeat (10) @(negedge clk);
    peek(2'd3, v2);
    chk(v2 == v1, "R10 debug halt", v2, v1);
    dbg = 0; idle = 1;
    repeat (10) @(negedge clk);
    peek(2'd3, v2);
    chk(v2 == v1 - 5, "R10 idle ignored", v2, v1 - 5);
    idle = 0;

    do_reset();
    @(negedge clk);
    wr(2'd1, mk_mode(200, 200, 0, 0, 0, 1));
    idle = 1; dbg = 1;
    peek(2'd3, v1);
    repeat (10) @(negedge clk);
    peek(2'd3, v2);
    chk(v2 == v1, "R10 idle halt", v2, v1);
    idle = 0; dbg = 0;

    // R2 R6: every window vs every restart point for reload 6
    for (int w = 0; w < 7; w++) begin
      for (int c = 0; c < 7; c++) begin
        do_reset();
        @(negedge clk);
        wr(2'd1, mk_mode(6, w, 0, 0, 0, 0));
        n = 0;
        peek(2'd3, d);
        while (d != c && n < 100) begin
          @(negedge clk); n++;
          peek(2'd3, d);
        end
        wr(2'd0, 32'hA5000001);
        peek(2'd3, v1);
        rd_stat(d);
        if (w < 6 && c > w) begin
          chk(d == 32'h2, "R6 early in sweep", d, 2);
        end else begin
          chk(d == 32'h0, "R2 legal restart no flag", d, 0);
          chk(v1 == 6, "R2 restart reload", v1, 6);
        end
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule